// File: doc/BRIEF.md
# Reset Source Discrimination Controller

This block gathers reset requests from four places: an active-low reset pad that is both read and pulled low by the block, a rising edge on a supply-good signal, a watchdog timeout pulse and a clock-failure pulse. Any request starts one common sequence. The block pulls the open-drain pad low for a fixed number of E-clock cycles and then lets it go. It waits for the pad to settle, then reads the pad again. If the pad is still low, something outside is holding it, so the reset is recorded as external. If the pad is high, the reset came from inside, and the latched internal requests decide which cause is recorded.

The block keeps the core in reset for the whole sequence. It reports a 2-bit cause code that selects the reset vector. The pad level goes through a two-flop synchroniser before anything inside uses it. The pad driver, the supply monitor, the watchdog counter and the clock detector sit outside this block and reach it only as levels and single-cycle pulses.

Top module: `rstsrc_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_rst_o` is 1, `rst_pin_drive_o` is 1 and `cause_o` is 00. After `rst_n` rises, the block completes one full sequence with cause 00.
- R2: A request that arrives while the block is idle makes `rst_pin_drive_o` go high for exactly DRIVE_CYC (default 4) consecutive cycles, provided no further request arrives during that window.
- R3: A watchdog, clock-failure or power-on request seen during the drive window restarts the drive count. `rst_pin_drive_o` then falls DRIVE_CYC cycles after the last edge at which a request was seen. With the defaults, a second request 2 cycles after the first gives a drive of 6 cycles, and a second request 3 cycles after the first gives 7 cycles.
- R4: The pad is judged by its level SETTLE_CYC (default 2) cycles after release. Passing that level through the two-flop synchroniser places the decision SETTLE_CYC+2 cycles after the drive falls. If the pad is low at that point, the cause becomes 00 (external). This holds even when internal requests are pending.
- R5: If the pad is high at the decision and only a watchdog request is pending, the cause becomes 01.
- R6: If the pad is high at the decision and a clock-failure request is pending, the cause becomes 10, including when a watchdog request is pending as well.
- R7: A power-on request comes only from a 0-to-1 change of `supply_good_i`, and it yields cause 00. A 1-to-0 change has no effect: `rst_pin_drive_o` and `core_rst_o` stay 0.
- R8: `core_rst_o` is 1 whenever `rst_pin_drive_o` is 1 and stays 1 until the decision. When the pad is high at the decision and no request is waiting, `core_rst_o` falls SETTLE_CYC+2 cycles after the drive falls. If the pad was still low at the decision, `core_rst_o` stays 1 until the synchronised pad is high.
- R9: `cause_o` changes only at a decision point. It holds its value while idle and during the drive window of the next sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | E-clock |
| rst_n | input | 1 | Active-low reset of the block's own registers |
| rst_pin_i | input | 1 | Level read back from the reset pad (low means asserted) |
| supply_good_i | input | 1 | Supply-good level; a rising edge is a power-on request |
| wdog_expire_i | input | 1 | Single-cycle watchdog timeout pulse |
| clk_fail_i | input | 1 | Single-cycle clock-failure pulse |
| rst_pin_drive_o | output | 1 | Open-drain enable; 1 pulls the reset pad low |
| core_rst_o | output | 1 | Reset to the core, active high |
| cause_o | output | 2 | Reset cause: 00 external or power-on, 01 watchdog, 10 clock failure |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the two internal sources: watchdog and clock-failure pulses are driven in one cycle, and the bench expects the cause to come out as 10. The second pair is pad discrimination and internal latching: a watchdog pulse is driven in the same cycle that the bench's pad model starts holding the pad low, and the bench expects cause 00, because the pad is still low at the decision. The scoreboard queues the expected drive width, the release gap and the cause for each sequence, and compares them as the design produces them.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;

  localparam logic [1:0] CAUSE_EXT = 2'b00;
  localparam logic [1:0] CAUSE_WD  = 2'b01;
  localparam logic [1:0] CAUSE_CM  = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_RELEASE = 2'd2,
    ST_HOLD    = 2'd3
  } seq_st_e;

  // Cause chosen at the decision point: a low pad wins, then clock failure.
  function automatic logic [1:0] pick_cause(input logic pad_high,
                                            input logic wd_pend,
                                            input logic cm_pend);
    logic [1:0] c;
    if (!pad_high)    c = CAUSE_EXT;
    else if (cm_pend) c = CAUSE_CM;
    else if (wd_pend) c = CAUSE_WD;
    else              c = CAUSE_EXT;
    return c;
  endfunction

  // Length of the post-release window, in cycles, measured on the synchronised pad.
  function automatic int release_len(input int settle, input int sync_stages);
    return settle + sync_stages;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstsrc_sync.sv
module rstsrc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] sh_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_r <= {STAGES{RST_VAL}};
        else        sh_r <= {sh_r[STAGES-2:0], d_i};
      end
      assign q_o = sh_r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rstsrc_req.sv
module rstsrc_req (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic idle_i,
  input  logic supply_good_i,
  input  logic wdog_i,
  input  logic cmon_i,
  input  logic clr_i,
  output logic por_evt_o,
  output logic new_evt_o,
  output logic start_evt_o,
  output logic pend_wd_o,
  output logic pend_cm_o,
  output logic pend_any_o
);

  logic supply_q;
  logic pend_wd_r, pend_cm_r, pend_por_r;
  logic ext_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) supply_q <= 1'b0;
    else        supply_q <= supply_good_i;
  end

  assign por_evt_o = supply_good_i & ~supply_q;
  assign new_evt_o = wdog_i | cmon_i | por_evt_o;
  // The pad counts as a request only while the block itself is not driving it.
  assign ext_lvl     = idle_i & ~pin_s_i;
  assign start_evt_o = new_evt_o | ext_lvl;

  // A new pulse on the same edge as a clear wins, so it is served next.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wd_r  <= 1'b0;
      pend_cm_r  <= 1'b0;
      pend_por_r <= 1'b0;
    end else begin
      pend_wd_r  <= (pend_wd_r  & ~clr_i) | wdog_i;
      pend_cm_r  <= (pend_cm_r  & ~clr_i) | cmon_i;
      pend_por_r <= (pend_por_r & ~clr_i) | por_evt_o;
    end
  end

  assign pend_wd_o  = pend_wd_r;
  assign pend_cm_o  = pend_cm_r;
  assign pend_any_o = pend_wd_r | pend_cm_r | pend_por_r;

endmodule

// File: rtl/rstsrc_seq.sv
module rstsrc_seq
  import rstsrc_pkg::*;
#(
  parameter int DRIVE_CYC   = 4,
  parameter int SETTLE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt_i,
  input  logic       new_evt_i,
  input  logic       pin_s_i,
  input  logic       pend_wd_i,
  input  logic       pend_cm_i,
  input  logic       pend_any_i,
  output logic       idle_o,
  output logic       drive_o,
  output logic       core_rst_o,
  output logic       sample_evt_o,
  output logic       restart_evt_o,
  output logic [1:0] cause_o
);

  localparam int REL_CYC = release_len(SETTLE_CYC, SYNC_STAGES);
  localparam int CW      = $clog2(max2(DRIVE_CYC, REL_CYC) + 1);
  localparam logic [CW-1:0] DRV_LAST = CW'(DRIVE_CYC - 1);
  localparam logic [CW-1:0] REL_LAST = CW'(REL_CYC - 1);

  seq_st_e       st_r, st_n;
  logic [CW-1:0] cnt_r, cnt_n;
  logic [1:0]    cause_r;

  assign sample_evt_o  = (st_r == ST_RELEASE) && (cnt_r == REL_LAST);
  assign restart_evt_o = (st_r == ST_DRIVE) && new_evt_i;

  always_comb begin
    st_n  = st_r;
    cnt_n = cnt_r;
    case (st_r)
      ST_IDLE: begin
        if (start_evt_i) begin
          st_n  = ST_DRIVE;
          cnt_n = '0;
        end
      end
      ST_DRIVE: begin
        if (new_evt_i) begin
          cnt_n = '0;
        end else if (cnt_r == DRV_LAST) begin
          st_n  = ST_RELEASE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_r + 1'b1;
        end
      end
      ST_RELEASE: begin
        if (cnt_r == REL_LAST) begin
          cnt_n = '0;
          if (!pin_s_i)       st_n = ST_HOLD;
          else if (new_evt_i) st_n = ST_DRIVE;
          else                st_n = ST_IDLE;
        end else begin
          cnt_n = cnt_r + 1'b1;
        end
      end
      ST_HOLD: begin
        cnt_n = '0;
        if (pin_s_i) st_n = (pend_any_i | new_evt_i) ? ST_DRIVE : ST_IDLE;
      end
      default: begin
        st_n  = ST_DRIVE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r    <= ST_DRIVE;
      cnt_r   <= '0;
      cause_r <= CAUSE_EXT;
    end else begin
      st_r  <= st_n;
      cnt_r <= cnt_n;
      if (sample_evt_o) cause_r <= pick_cause(pin_s_i, pend_wd_i, pend_cm_i);
    end
  end

  assign idle_o     = (st_r == ST_IDLE);
  assign drive_o    = (st_r == ST_DRIVE);
  assign core_rst_o = (st_r != ST_IDLE);
  assign cause_o    = cause_r;

endmodule

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl #(
  parameter int DRIVE_CYC   = 4,
  parameter int SETTLE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin_i,
  input  logic       supply_good_i,
  input  logic       wdog_expire_i,
  input  logic       clk_fail_i,
  output logic       rst_pin_drive_o,
  output logic       core_rst_o,
  output logic [1:0] cause_o
);

  // Named internal events, also observed by the bound checker.
  logic pin_s;
  logic idle;
  logic por_evt;
  logic new_evt;
  logic start_evt;
  logic pend_wd;
  logic pend_cm;
  logic pend_any;
  logic sample_evt;
  logic restart_evt;

  rstsrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rst_pin_i),
    .q_o   (pin_s)
  );

  rstsrc_req u_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_s_i       (pin_s),
    .idle_i        (idle),
    .supply_good_i (supply_good_i),
    .wdog_i        (wdog_expire_i),
    .cmon_i        (clk_fail_i),
    .clr_i         (sample_evt),
    .por_evt_o     (por_evt),
    .new_evt_o     (new_evt),
    .start_evt_o   (start_evt),
    .pend_wd_o     (pend_wd),
    .pend_cm_o     (pend_cm),
    .pend_any_o    (pend_any)
  );

  rstsrc_seq #(
    .DRIVE_CYC   (DRIVE_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_evt_i   (start_evt),
    .new_evt_i     (new_evt),
    .pin_s_i       (pin_s),
    .pend_wd_i     (pend_wd),
    .pend_cm_i     (pend_cm),
    .pend_any_i    (pend_any),
    .idle_o        (idle),
    .drive_o       (rst_pin_drive_o),
    .core_rst_o    (core_rst_o),
    .sample_evt_o  (sample_evt),
    .restart_evt_o (restart_evt),
    .cause_o       (cause_o)
  );

endmodule

// File: rtl/rstsrc_checker.sv
module rstsrc_checker #(
  parameter int DRIVE_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       drive,
  input logic       core_rst,
  input logic [1:0] cause,
  input logic       pin_s,
  input logic       sample_evt,
  input logic       restart_evt,
  input logic       pend_wd,
  input logic       pend_cm
);

  localparam int CW = $clog2(DRIVE_CYC + 2);

  logic [CW-1:0] drv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           drv_cnt <= '0;
    else if (!drive)      drv_cnt <= '0;
    else if (restart_evt) drv_cnt <= '0;
    else                  drv_cnt <= drv_cnt + 1'b1;
  end

  assert_drive_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (drv_cnt <= CW'(DRIVE_CYC)));

  assert_drive_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive) |-> (drv_cnt == CW'(DRIVE_CYC)));

  assert_ext_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !pin_s) |=> (cause == 2'b00));

  assert_wd_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && pin_s && pend_wd && !pend_cm) |=> (cause == 2'b01));

  assert_cm_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && pin_s && pend_cm) |=> (cause == 2'b10));

  assert_drive_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> core_rst);

  assert_release_pad_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> $past(pin_s));

  assert_cause_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> $stable(cause));

endmodule

bind rstsrc_ctrl rstsrc_checker #(.DRIVE_CYC(DRIVE_CYC)) u_rstsrc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drive       (rst_pin_drive_o),
  .core_rst    (core_rst_o),
  .cause       (cause_o),
  .pin_s       (pin_s),
  .sample_evt  (sample_evt),
  .restart_evt (restart_evt),
  .pend_wd     (pend_wd),
  .pend_cm     (pend_cm)
);

// File: tb/rstsrc_ctrl_bench.sv
module rstsrc_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;
  localparam int DRV        = 4;
  localparam int GAP        = 2 + 2;

  typedef struct {
    int         gap;
    logic [1:0] cause;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0;
  logic wdog = 1'b0;
  logic cmon = 1'b0;
  logic ext_low = 1'b0;
  logic drive, core_rst;
  logic [1:0] cause;
  logic pad;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int   q_width[$];
  res_t q_res[$];

  assign pad = ~(drive | ext_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  rstsrc_ctrl u_rstsrc_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .rst_pin_i       (pad),
    .supply_good_i   (supply_good),
    .wdog_expire_i   (wdog),
    .clk_fail_i      (cmon),
    .rst_pin_drive_o (drive),
    .core_rst_o      (core_rst),
    .cause_o         (cause)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_seq(input int width, input int gap, input logic [1:0] c);
    res_t r;
    r.gap = gap;
    r.cause = c;
    q_width.push_back(width);
    q_res.push_back(r);
  endtask

  // Monitor: drive width, release gap and cause as each sequence completes.
  int  w_cnt = 0;
  int  g_cnt = 0;
  logic drv_q = 1'b0;
  logic core_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (drive) w_cnt++;
      if (drv_q && !drive) begin
        if (q_width.size() == 0) chk("R2 unexpected drive", 1, 0);
        else begin
          int ew;
          ew = q_width.pop_front();
          if (ew >= 0) chk("R2/R3 drive width", w_cnt, ew);
        end
        w_cnt = 0;
        g_cnt = 0;
      end else if (!drive) begin
        g_cnt++;
      end
      if (core_q && !core_rst) begin
        if (q_res.size() == 0) chk("R8 unexpected release", 1, 0);
        else begin
          res_t r;
          r = q_res.pop_front();
          if (r.gap >= 0) chk("R8 release gap", g_cnt, r.gap);
          chk("R4/R5/R6/R7 cause", int'(cause), int'(r.cause));
        end
      end
      drv_q  = drive;
      core_q = core_rst;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while ((core_rst || q_res.size() != 0) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    cyc(3);
  endtask

  task automatic pulse_wd();
    wdog = 1'b1; @(negedge clk); wdog = 1'b0;
  endtask

  task automatic pulse_cm();
    cmon = 1'b1; @(negedge clk); cmon = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    // R1: state held during block reset
    cyc(3);
    chk("R1 core_rst in reset", int'(core_rst), 1);
    chk("R1 drive in reset", int'(drive), 1);
    chk("R1 cause in reset", int'(cause), 0);
    expect_seq(-1, GAP, 2'b00);
    rst_n = 1'b1;
    wait_idle();
    chk("R1 idle after start-up", int'(core_rst), 0);

    // R7: rising supply edge is a power-on request
    expect_seq(DRV, GAP, 2'b00);
    supply_good = 1'b1;
    wait_idle();

    // R7: falling supply edge is ignored
    supply_good = 1'b0;
    cyc(10);
    chk("R7 no drive on supply drop", int'(drive), 0);
    chk("R7 no core reset on supply drop", int'(core_rst), 0);

    // R5: watchdog only
    expect_seq(DRV, GAP, 2'b01);
    pulse_wd();
    wait_idle();

    // R9: cause held while idle
    cyc(20);
    chk("R9 cause held idle", int'(cause), 1);

    // R6: clock failure; R9 old cause kept during the drive window
    expect_seq(DRV, GAP, 2'b10);
    pulse_cm();
    cyc(1);
    chk("R9 cause held in drive", int'(cause), 1);
    wait_idle();

    // R6: both internal sources in the same cycle
    expect_seq(DRV, GAP, 2'b01);
    pulse_wd();
    wait_idle();
    expect_seq(DRV, GAP, 2'b10);
    wdog = 1'b1; cmon = 1'b1; @(negedge clk); wdog = 1'b0; cmon = 1'b0;
    wait_idle();

    // R3: restart two cycles in
    expect_seq(DRV + 2, GAP, 2'b10);
    pulse_wd();
    cyc(1);
    pulse_cm();
    wait_idle();

    // R3: restart three cycles in
    expect_seq(DRV + 3, GAP, 2'b01);
    pulse_wd();
    cyc(2);
    pulse_wd();
    wait_idle();

    // R4: pad held low from outside; R8 core reset kept past the decision
    expect_seq(DRV, -1, 2'b00);
    ext_low = 1'b1;
    cyc(13);
    chk("R8 core_rst held while pad low", int'(core_rst), 1);
    cyc(3);
    ext_low = 1'b0;
    wait_idle();
    chk("R4 cause external", int'(cause), 0);

    // R4: pad low wins over a watchdog pulse in the same cycle
    expect_seq(DRV, GAP, 2'b01);
    pulse_wd();
    wait_idle();
    expect_seq(DRV, -1, 2'b00);
    ext_low = 1'b1;
    pulse_wd();
    cyc(15);
    ext_low = 1'b0;
    wait_idle();

    chk("R2 all drives seen", q_width.size(), 0);
    chk("R8 all releases seen", q_res.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule